// File: doc/BRIEF.md
# Geometry command word unpacker

This block sits between a 32-bit register bus and the command queue of a 3D geometry engine. Software can issue commands to it in two ways. The first is a packed port, where one word carries up to four opcodes and is followed by the parameter words those opcodes need. The second is a window of direct ports, where the opcode comes from the write address and each write carries exactly one parameter. The block turns both into a single stream of (opcode, parameter) entries on a valid/ready output.

A fixed opcode-to-parameter-count function decides how many bus words each packed opcode consumes. Opcodes that take no parameters are sent out by the block itself, with no bus write needed to trigger them. When the queue stops accepting entries, the block holds the bus with a wait signal and keeps its own state unchanged.

Top module: `geom_cmd_unpacker`

## Requirements
- R1: After reset the block is waiting for a command word. It raises neither `out_valid` nor `wr_wait` until a write arrives.
- R2: A write to byte offsets 0x400 to 0x43F while no packed sequence is active is taken as four opcodes. Opcode 0 is data bits 7:0, then 15:8, then 23:16, then 31:24. That write produces no output entry.
- R3: Parameter counts are: 0x10, 0x12, 0x13, 0x14, 0x20 to 0x2B except 0x23, 0x30 to 0x33, 0x40, 0x50, 0x60 and 0x72 take 1. 0x23 and 0x71 take 2. 0x1B, 0x1C and 0x70 take 3. 0x1A takes 9. 0x17 and 0x19 take 12. 0x16 and 0x18 take 16. 0x34 takes 32. Every other opcode takes 0.
- R4: During a packed sequence, each write to the packed range emits one entry. The entry has `out_cmd` set to the current opcode and `out_param` set to the written data. After the opcode's last parameter the next opcode becomes current.
- R5: An opcode with a count of 0 is emitted with `out_param` = 0 and needs no bus write. While such an entry is pending, any write to the packed or direct range sees `wr_wait` high.
- R6: Once all four opcodes of a word are consumed, the next packed-range write is again a new command word.
- R7: A write to offsets 0x440 to 0x5CB emits one entry with `out_cmd` = {0, address bits 8:2} and `out_param` = the data, whatever the packed state is. It leaves the packed state unchanged.
- R8: Writes outside 0x400 to 0x5CB produce no entry and no wait, and they leave the packed state unchanged.
- R9: While `out_valid` is high and `out_ready` is low, `wr_wait` is high for any bus write in range. The entry and the block's state are held until the entry is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, held until `wr_wait` is low |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | 32 | Write data |
| wr_wait | output | 1 | Write not taken this cycle, hold it |
| out_valid | output | 1 | Entry offered to the queue |
| out_cmd | output | 8 | Opcode of the entry |
| out_param | output | 32 | Parameter of the entry |
| out_ready | input | 1 | Queue accepts the entry |

## Verification
The bench tries several input patterns.
- A word made only of zero-count opcodes shows that lowest-byte-first order and self-emission work without bus traffic.
- Words mixing long and short counts (1, 2, 3, 9, 12, 16, 32) separate a correct count lookup from off-by-one advances.
- Direct-port and out-of-range writes placed mid-sequence show that neither disturbs the remembered opcode and remaining count.
- A direct write issued while zero-count entries are draining shows the wait priority.

The whole set is then repeated with an irregular `out_ready`, to tell real holding apart from lucky timing.

// File: rtl/geom_cmd_unpacker.sv
module geom_cmd_unpacker #(
  parameter int              ADDR_W  = 12,
  parameter logic [11:0]     PACK_LO = 12'h400,
  parameter logic [11:0]     PACK_HI = 12'h43F,
  parameter logic [11:0]     DIR_LO  = 12'h440,
  parameter logic [11:0]     DIR_HI  = 12'h5CB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic              wr_wait,
  output logic              out_valid,
  output logic [7:0]        out_cmd,
  output logic [31:0]       out_param,
  input  logic              out_ready
);
  localparam int CMD_W  = 8;
  localparam int DATA_W = 32;
  localparam int SLOTS  = DATA_W / CMD_W;
  localparam int SLOT_W = $clog2(SLOTS + 1);
  localparam int CNT_W  = 6;

  function automatic int param_count(input logic [CMD_W-1:0] op);
    case (op) inside
      8'h23, 8'h71:                      return 2;
      8'h10, 8'h12, 8'h13, 8'h14:        return 1;
      [8'h20:8'h2B], [8'h30:8'h33]:      return 1;
      8'h40, 8'h50, 8'h60, 8'h72:        return 1;
      8'h1B, 8'h1C, 8'h70:               return 3;
      8'h1A:                             return 9;
      8'h17, 8'h19:                      return 12;
      8'h16, 8'h18:                      return 16;
      8'h34:                             return 32;
      default:                           return 0;
    endcase
  endfunction

  logic [DATA_W-1:0] word_q;
  logic [SLOT_W-1:0] slots_q;
  logic [CNT_W-1:0]  left_q;

  logic active, auto_emit, in_pack, in_dir, emit_bus, fire, step_cmd, load;
  logic [CMD_W-1:0] cur_op;

  assign active    = slots_q != '0;
  assign cur_op    = word_q[CMD_W-1:0];
  assign auto_emit = active && left_q == '0;
  assign in_pack   = wr_en && {{(12-ADDR_W > 0 ? 0 : 0){1'b0}}, wr_addr} >= ADDR_W'(PACK_LO)
                     && wr_addr <= ADDR_W'(PACK_HI);
  assign in_dir    = wr_en && wr_addr >= ADDR_W'(DIR_LO) && wr_addr <= ADDR_W'(DIR_HI);
  assign emit_bus  = !auto_emit && (in_dir || (in_pack && active));

  assign out_valid = auto_emit || emit_bus;
  assign out_cmd   = (!auto_emit && in_dir) ? {1'b0, wr_addr[8:2]} : cur_op;
  assign out_param = auto_emit ? '0 : wr_data;
  assign wr_wait   = (auto_emit && (in_pack || in_dir)) || (emit_bus && !out_ready);

  assign fire     = out_valid && out_ready;
  assign load     = in_pack && !active;
  assign step_cmd = fire && (auto_emit || (!in_dir && left_q == CNT_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q  <= '0;
      slots_q <= '0;
      left_q  <= '0;
    end else if (load) begin
      word_q  <= wr_data;
      slots_q <= SLOT_W'(SLOTS);
      left_q  <= CNT_W'(param_count(wr_data[CMD_W-1:0]));
    end else if (step_cmd) begin
      word_q  <= word_q >> CMD_W;
      slots_q <= slots_q - SLOT_W'(1);
      left_q  <= CNT_W'(param_count(word_q[2*CMD_W-1:CMD_W]));
    end else if (fire && !in_dir) begin
      left_q  <= left_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/geom_cmd_unpacker_chk.sv
module geom_cmd_unpacker_chk #(
  parameter int          ADDR_W  = 12,
  parameter logic [11:0] PACK_LO = 12'h400,
  parameter logic [11:0] DIR_LO  = 12'h440,
  parameter logic [11:0] DIR_HI  = 12'h5CB
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              wr_wait,
  input logic              out_valid,
  input logic [7:0]        out_cmd,
  input logic [31:0]       out_param,
  input logic              out_ready
);
  logic dir_hit, outside;
  assign dir_hit = wr_en && wr_addr >= ADDR_W'(DIR_LO) && wr_addr <= ADDR_W'(DIR_HI);
  assign outside = wr_en && (wr_addr < ADDR_W'(PACK_LO) || wr_addr > ADDR_W'(DIR_HI));

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) && !wr_en |-> !out_valid && !wr_wait);

  a_r5_self_entry_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !wr_en |-> out_param == 32'h0);

  a_r7_direct_entry: assert property (@(posedge clk) disable iff (!rst_n)
    dir_hit && !wr_wait |-> out_valid && out_cmd == {1'b0, wr_addr[8:2]} && out_param == wr_data);

  a_r8_outside_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    outside |-> !wr_wait);

  a_r9_wait_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && out_valid && !out_ready |-> wr_wait);

  a_r9_self_entry_held: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !wr_en |=> out_valid && $stable(out_cmd) && out_param == 32'h0);
endmodule

bind geom_cmd_unpacker geom_cmd_unpacker_chk #(
  .ADDR_W(ADDR_W), .PACK_LO(PACK_LO), .DIR_LO(DIR_LO), .DIR_HI(DIR_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .wr_wait(wr_wait), .out_valid(out_valid), .out_cmd(out_cmd), .out_param(out_param),
  .out_ready(out_ready)
);

// File: tb/test_geom_cmd_unpacker.sv
module test_geom_cmd_unpacker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        wr_wait, out_valid, out_ready;
  logic [7:0]  out_cmd;
  logic [31:0] out_param;

  int errors = 0, checks = 0, cycles = 0;
  int ready_mode = 0;
  bit done = 0;
  string req = "R1";

  int q[$];
  int mleft = 0;

  always #10 clk = ~clk;

  geom_cmd_unpacker i_geom_cmd_unpacker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_wait(wr_wait), .out_valid(out_valid), .out_cmd(out_cmd), .out_param(out_param),
    .out_ready(out_ready)
  );

  function automatic int cnt(input int op);
    if (op == 'h23 || op == 'h71) return 2;
    if (op == 'h10 || op == 'h12 || op == 'h13 || op == 'h14) return 1;
    if ((op >= 'h20 && op <= 'h2B) || (op >= 'h30 && op <= 'h33)) return 1;
    if (op == 'h40 || op == 'h50 || op == 'h60 || op == 'h72) return 1;
    if (op == 'h1B || op == 'h1C || op == 'h70) return 3;
    if (op == 'h1A) return 9;
    if (op == 'h17 || op == 'h19) return 12;
    if (op == 'h16 || op == 'h18) return 16;
    if (op == 'h34) return 32;
    return 0;
  endfunction

  task automatic chk(input string r, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (t=%0t)", r, what, act, exp, $time);
    end
  endtask

  // reference model, compared every cycle away from the edge
  always @(negedge clk) begin
    if (!rst_n) begin
      q.delete();
      mleft = 0;
    end else begin
      bit auto_e, hd, hp, ev, ew;
      int ec;
      longint ep;
      auto_e = q.size() > 0 && mleft == 0;
      hd = wr_en && wr_addr >= 12'h440 && wr_addr <= 12'h5CB;
      hp = wr_en && wr_addr >= 12'h400 && wr_addr <= 12'h43F;
      ev = 0; ew = 0; ec = 0; ep = 0;
      if (auto_e) begin
        ev = 1; ec = q[0]; ep = 0; ew = hd || hp;
      end else if (hd) begin
        ev = 1; ec = (int'(wr_addr) >> 2) & 'h7F; ep = wr_data; ew = !out_ready;
      end else if (hp && q.size() > 0) begin
        ev = 1; ec = q[0]; ep = wr_data; ew = !out_ready;
      end
      chk(req, "out_valid", out_valid, ev);
      chk(req, "wr_wait", wr_wait, ew);
      if (ev) begin
        chk(req, "out_cmd", out_cmd, ec);
        chk(req, "out_param", out_param, ep);
      end
      if (auto_e) begin
        if (out_ready) begin
          void'(q.pop_front());
          mleft = q.size() > 0 ? cnt(q[0]) : 0;
        end
      end else if (hd) begin
      end else if (hp && q.size() > 0) begin
        if (out_ready) begin
          mleft--;
          if (mleft == 0) begin
            void'(q.pop_front());
            mleft = q.size() > 0 ? cnt(q[0]) : 0;
          end
        end
      end else if (hp) begin
        for (int i = 0; i < 4; i++) q.push_back(int'((wr_data >> (8 * i)) & 32'hFF));
        mleft = cnt(q[0]);
      end
    end
  end

  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      out_ready = (ready_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      finish_run();
    end
  end

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    forever begin
      @(negedge clk);
      if (!wr_wait) break;
    end
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic params(input int n, input int seed);
    for (int i = 0; i < n; i++) bus_wr(12'h400 + 12'((i % 16) * 4), 32'(seed * 1000 + i + 1));
  endtask

  task automatic scenarios();
    // R2 R5: all zero-count opcodes, lowest byte first
    req = "R2"; bus_wr(12'h400, 32'h0041_1511); drain();
    // R3 R4: 32 then 1 parameters, then two zero-count
    req = "R4"; bus_wr(12'h43C, 32'h0000_1034); params(33, 1); drain();
    // R3: 3, 12, 2, 3
    req = "R3"; bus_wr(12'h404, 32'h1B23_1770); params(20, 2); drain();
    // R6: word after a fully consumed word; 9, 16, 2, 1
    req = "R6"; bus_wr(12'h400, 32'h7271_161A); params(28, 3); drain();
    // R7: direct writes, also in the middle of a packed sequence
    req = "R7"; bus_wr(12'h440, 32'hCAFE_0001); bus_wr(12'h5C8, 32'h0000_0002);
    bus_wr(12'h400, 32'h0000_0018); params(3, 4);
    bus_wr(12'h48C, 32'h1234_5678); params(13, 5); drain();
    // R8: out-of-range writes mid-sequence leave state alone
    req = "R8"; bus_wr(12'h400, 32'h0000_0070); params(1, 6);
    bus_wr(12'h000, 32'hFFFF_FFFF); bus_wr(12'h3FC, 32'h0000_0011);
    bus_wr(12'h5CC, 32'h0000_0022); bus_wr(12'hFFC, 32'h0000_0033);
    params(2, 7); drain();
    // R5: direct write while zero-count entries are pending
    req = "R5"; bus_wr(12'h400, 32'h0000_0000); bus_wr(12'h444, 32'h0000_00AB); drain();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    req = "R1";
    chk("R1", "out_valid after reset", out_valid, 0);
    chk("R1", "wr_wait after reset", wr_wait, 0);
    scenarios();
    req = "R9"; ready_mode = 1;
    scenarios();
    req = "R9"; bus_wr(12'h400, 32'h1111_0000); drain();
    ready_mode = 0;
    repeat (3) @(negedge clk);
    chk("R6", "model idle at end", q.size(), 0);
    finish_run();
  end
endmodule